// File: doc/BRIEF.md
# Shared-Content Instruction Cache

This block is a set-associative instruction cache in which a data block can be reached through more than one address tag. Each tag entry carries a valid bit, its tag and a pointer into a shared pool of data slots. Each slot keeps a count of the tags that point at it, and a slot becomes free only when that count returns to zero. The fetch side presents a byte address and receives the whole 32-byte block, which holds four 64-bit instructions, together with a hit flag.

On a tag miss the cache first sends the block key of the missed address (its tag-index) to an external duplicate-relation table. If the table names a duplicate key and that key is resident, the cache returns the duplicate's content and makes no request to lower memory. The duplicate's replacement age is refreshed exactly as for a hit. No victim is evicted and no data slot is allocated. The missed key is recorded as an extra tag on the shared slot only when its own set has an empty way. Otherwise the block is refilled from lower memory into a victim way chosen by LRU.

Only one miss is in flight at a time. While it is being resolved, `fetch_ready` stays low. A `flush` pulse clears every tag, every slot count and all LRU state in one cycle. The fetch request and the refill request use valid/ready handshakes: a request is held, unchanged, until ready is seen high at a clock edge. The response, the duplicate answer and the refill data are single-cycle valid pulses without back-pressure, and the receiver must take them in that cycle.

Top module: `uc_icache`

## Requirements
- R1: A fetch accepted (`fetch_valid` and `fetch_ready` high at an edge) whose block is resident gives `resp_valid` with `resp_hit`=1 and the stored block on `resp_data` one cycle after acceptance, and makes no duplicate or refill request.
- R2: On a miss that is not resolved by a duplicate, `mem_req_valid` is raised with `mem_req_key` equal to address bits [ADDR_W-1:5] and is held until `mem_req_ready`. The cycle after `mem_rsp_valid`, `resp_valid` pulses with `resp_hit`=0 and the refill data, and later fetches of that block hit.
- R3: Every miss first raises `dup_req_valid` with `dup_req_key` equal to the missed block key, held until `dup_rsp_valid`.
- R4: If `dup_rsp_found`=1 and the block named by `dup_rsp_key` is resident, `resp_valid` pulses the cycle after `dup_rsp_valid` with `resp_hit`=0 and that block's content, and no refill request is made.
- R5: A duplicate resolution refreshes the duplicate's LRU age exactly as a hit would.
- R6: A duplicate resolution evicts nothing. If the missed set has an empty way, the missed key becomes a tag on the duplicate's slot and later fetches of it hit. If the missed set is full, later fetches of that key miss again.
- R7: A refill goes into the lowest-numbered empty way of its set, or into the least recently used way when the set is full.
- R8: `fetch_ready` is low from the edge that accepts a missing fetch until its response cycle. The duplicate and refill requests are never raised together.
- R9: `fetch_ready` is low during a `flush` cycle. After a flush, every block misses.
- R10: A slot shared by several tags keeps its content while any of those tags is valid, even after the tag that first filled it has been evicted.
- R11: Address bits [4:0] select nothing. The set is block key bits [IDX_W-1:0] and the tag is the remaining upper key bits. Instruction i of a block occupies `resp_data` bits [64i+63:64i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clears all tags, slot counts and LRU state |
| fetch_valid | input | 1 | Fetch request present |
| fetch_ready | output | 1 | Cache can accept a fetch |
| fetch_addr | input | ADDR_W | Byte address of the fetch |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | 1 when the tag was resident at acceptance |
| resp_data | output | BLK_W | Fetched 32-byte block |
| dup_req_valid | output | 1 | Duplicate query pending |
| dup_req_key | output | KEY_W | Block key of the missed address |
| dup_rsp_valid | input | 1 | Duplicate answer pulse |
| dup_rsp_found | input | 1 | Table holds a duplicate for the key |
| dup_rsp_key | input | KEY_W | Block key of the duplicate |
| mem_req_valid | output | 1 | Refill request pending |
| mem_req_ready | input | 1 | Lower memory accepts the refill request |
| mem_req_key | output | KEY_W | Block key to refill |
| mem_rsp_valid | input | 1 | Refill data pulse |
| mem_rsp_data | input | BLK_W | Refill block content |

## Verification
A hit response is due one cycle after the accepting edge. A duplicate-served response is due one cycle after the duplicate answer, and a refill response one cycle after the refill data. The bench drives every input on falling edges and reads outputs on falling edges. It counts the falling edges from acceptance to `resp_valid`, so a hit is checked to arrive at exactly the first one, and it checks `fetch_ready` at that same point. Refill and duplicate queries are counted by the bench's own responders. A duplicate-served miss is therefore checked by an unchanged refill count, and LRU effects are checked through which later fetches hit or refill.

// File: rtl/uc_pkg.sv
package uc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DUPQ  = 2'd1,
    ST_MREQ  = 2'd2,
    ST_MWAIT = 2'd3
  } uc_state_e;
endpackage

// File: rtl/uc_tag_store.sv
module uc_tag_store #(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int TAG_W  = 9,
  parameter int SLOT_W = 3,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic [IDX_W-1:0]        a_set,
  input  logic [TAG_W-1:0]        a_tag,
  output logic                    a_hit,
  output logic [WAY_W-1:0]        a_way,
  output logic [SLOT_W-1:0]       a_slot,
  input  logic [IDX_W-1:0]        b_set,
  input  logic [TAG_W-1:0]        b_tag,
  output logic                    b_hit,
  output logic [WAY_W-1:0]        b_way,
  output logic [SLOT_W-1:0]       b_slot,
  input  logic [IDX_W-1:0]        v_set,
  output logic [WAYS-1:0]         v_valid,
  output logic [WAYS*SLOT_W-1:0]  v_slot,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_set,
  input  logic [WAY_W-1:0]        wr_way,
  input  logic [TAG_W-1:0]        wr_tag,
  input  logic [SLOT_W-1:0]       wr_slot
);
  logic [WAYS-1:0]   valid_q [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [SLOT_W-1:0] slot_q  [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (wr_en) begin
      valid_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]  <= '0;
          slot_q[s][w] <= '0;
        end
    end else if (wr_en && !flush) begin
      tag_q[wr_set][wr_way]  <= wr_tag;
      slot_q[wr_set][wr_way] <= wr_slot;
    end
  end

  always_comb begin
    a_hit = 1'b0; a_way = '0; a_slot = '0;
    b_hit = 1'b0; b_way = '0; b_slot = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid_q[a_set][w] && tag_q[a_set][w] == a_tag) begin
        a_hit = 1'b1; a_way = WAY_W'(w); a_slot = slot_q[a_set][w];
      end
      if (valid_q[b_set][w] && tag_q[b_set][w] == b_tag) begin
        b_hit = 1'b1; b_way = WAY_W'(w); b_slot = slot_q[b_set][w];
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_view
    assign v_valid[w]                  = valid_q[v_set][w];
    assign v_slot[w*SLOT_W +: SLOT_W]  = slot_q[v_set][w];
  end
endmodule

// File: rtl/uc_lru.sv
module uc_lru #(
  parameter int SETS = 4,
  parameter int WAYS = 2,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [IDX_W-1:0] q_set,
  output logic [WAY_W-1:0] q_oldest
);
  // Age 0 is most recent; ages in a set are always a permutation.
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] ref_age;

  assign ref_age = age_q[touch_set][touch_way];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < ref_age)
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    q_oldest = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[q_set][w] == WAY_W'(WAYS-1)) q_oldest = WAY_W'(w);
  end
endmodule

// File: rtl/uc_slot_pool.sv
module uc_slot_pool #(
  parameter int NSLOT = 8,
  parameter int BLK_W = 256,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int RC_W   = $clog2(NSLOT+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              inc_en,
  input  logic [SLOT_W-1:0] inc_slot,
  input  logic              dec_en,
  input  logic [SLOT_W-1:0] dec_slot,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [BLK_W-1:0]  wr_data,
  input  logic [SLOT_W-1:0] rd_a_slot,
  output logic [BLK_W-1:0]  rd_a_data,
  input  logic [SLOT_W-1:0] rd_b_slot,
  output logic [BLK_W-1:0]  rd_b_data,
  input  logic [SLOT_W-1:0] cnt_slot,
  output logic [RC_W-1:0]   cnt_val,
  output logic [SLOT_W-1:0] free_slot
);
  logic [RC_W-1:0]  rc_q [NSLOT];
  logic [RC_W-1:0]  rc_d [NSLOT];
  logic [BLK_W-1:0] data_q [NSLOT];

  always_comb begin
    for (int i = 0; i < NSLOT; i++)
      rc_d[i] = rc_q[i]
              + RC_W'(inc_en && inc_slot == SLOT_W'(i))
              - RC_W'(dec_en && dec_slot == SLOT_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int i = 0; i < NSLOT; i++) rc_q[i] <= '0;
    end else begin
      for (int i = 0; i < NSLOT; i++) rc_q[i] <= rc_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) data_q[wr_slot] <= wr_data;
  end

  always_comb begin
    free_slot = '0;
    for (int i = NSLOT-1; i >= 0; i--)
      if (rc_q[i] == '0) free_slot = SLOT_W'(i);
  end

  assign rd_a_data = data_q[rd_a_slot];
  assign rd_b_data = data_q[rd_b_slot];
  assign cnt_val   = rc_q[cnt_slot];
endmodule

// File: rtl/uc_icache.sv
module uc_icache #(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 256,
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  localparam int OFF_W  = $clog2(BLK_W/8),
  localparam int KEY_W  = ADDR_W - OFF_W,
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = KEY_W - IDX_W,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int NSLOT  = SETS * WAYS,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int RC_W   = $clog2(NSLOT+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [BLK_W-1:0]  resp_data,
  output logic              dup_req_valid,
  output logic [KEY_W-1:0]  dup_req_key,
  input  logic              dup_rsp_valid,
  input  logic              dup_rsp_found,
  input  logic [KEY_W-1:0]  dup_rsp_key,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [KEY_W-1:0]  mem_req_key,
  input  logic              mem_rsp_valid,
  input  logic [BLK_W-1:0]  mem_rsp_data
);
  import uc_pkg::*;

  uc_state_e        state_q;
  logic [KEY_W-1:0] miss_key_q;

  logic [KEY_W-1:0] f_key;
  logic [IDX_W-1:0] f_set, m_set, d_set;
  logic [TAG_W-1:0] f_tag, m_tag, d_tag;

  assign f_key = fetch_addr[ADDR_W-1:OFF_W];
  assign f_set = f_key[IDX_W-1:0];
  assign f_tag = f_key[KEY_W-1:IDX_W];
  assign m_set = miss_key_q[IDX_W-1:0];
  assign m_tag = miss_key_q[KEY_W-1:IDX_W];
  assign d_set = dup_rsp_key[IDX_W-1:0];
  assign d_tag = dup_rsp_key[KEY_W-1:IDX_W];

  logic                   a_hit, b_hit;
  logic [WAY_W-1:0]       a_way, b_way, lru_way;
  logic [SLOT_W-1:0]      a_slot, b_slot;
  logic [WAYS-1:0]        v_valid;
  logic [WAYS*SLOT_W-1:0] v_slot;
  logic                   tw_en;
  logic [WAY_W-1:0]       tw_way;
  logic [TAG_W-1:0]       tw_tag;
  logic [SLOT_W-1:0]      tw_slot;
  logic                   lt_en;
  logic [IDX_W-1:0]       lt_set;
  logic [WAY_W-1:0]       lt_way;
  logic                   inc_en, dec_en;
  logic [SLOT_W-1:0]      inc_slot, free_slot;
  logic [RC_W-1:0]        vic_cnt;
  logic [BLK_W-1:0]       rd_a_data, rd_b_data;

  // Handshake and miss-resolution events
  logic accept, dup_take, dup_res, refill_done;
  assign fetch_ready = (state_q == ST_IDLE) && !flush;
  assign accept      = fetch_valid && fetch_ready;
  assign dup_take    = (state_q == ST_DUPQ) && dup_rsp_valid;
  assign dup_res     = dup_take && dup_rsp_found && b_hit;
  assign refill_done = (state_q == ST_MWAIT) && mem_rsp_valid;

  // Victim selection in the missed set
  logic              has_inv, vic_valid, reuse;
  logic [WAY_W-1:0]  inv_way, victim;
  logic [SLOT_W-1:0] vic_slot, new_slot;

  always_comb begin
    has_inv = 1'b0;
    inv_way = '0;
    for (int w = WAYS-1; w >= 0; w--)
      if (!v_valid[w]) begin
        has_inv = 1'b1;
        inv_way = WAY_W'(w);
      end
  end

  assign victim    = has_inv ? inv_way : lru_way;
  assign vic_valid = v_valid[victim];
  assign vic_slot  = v_slot[32'(victim)*SLOT_W +: SLOT_W];
  assign reuse     = vic_valid && (vic_cnt == RC_W'(1));
  assign new_slot  = reuse ? vic_slot : free_slot;

  always_comb begin
    tw_en = 1'b0; tw_way = victim; tw_tag = m_tag; tw_slot = new_slot;
    inc_en = 1'b0; inc_slot = new_slot;
    if (refill_done) begin
      tw_en  = 1'b1;
      inc_en = !reuse;
    end else if (dup_res && has_inv) begin
      tw_en    = 1'b1;
      tw_way   = inv_way;
      tw_slot  = b_slot;
      inc_en   = 1'b1;
      inc_slot = b_slot;
    end
  end
  assign dec_en = refill_done && vic_valid && !reuse;

  always_comb begin
    lt_en = 1'b0; lt_set = m_set; lt_way = victim;
    if (accept && a_hit) begin
      lt_en = 1'b1; lt_set = f_set; lt_way = a_way;
    end else if (dup_res) begin
      lt_en = 1'b1; lt_set = d_set; lt_way = b_way;
    end else if (refill_done) begin
      lt_en = 1'b1;
    end
  end

  uc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .a_set(f_set), .a_tag(f_tag), .a_hit(a_hit), .a_way(a_way), .a_slot(a_slot),
    .b_set(d_set), .b_tag(d_tag), .b_hit(b_hit), .b_way(b_way), .b_slot(b_slot),
    .v_set(m_set), .v_valid(v_valid), .v_slot(v_slot),
    .wr_en(tw_en), .wr_set(m_set), .wr_way(tw_way), .wr_tag(tw_tag), .wr_slot(tw_slot)
  );

  uc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .touch_en(lt_en), .touch_set(lt_set), .touch_way(lt_way),
    .q_set(m_set), .q_oldest(lru_way)
  );

  uc_slot_pool #(.NSLOT(NSLOT), .BLK_W(BLK_W)) u_pool (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .inc_en(inc_en), .inc_slot(inc_slot),
    .dec_en(dec_en), .dec_slot(vic_slot),
    .wr_en(refill_done), .wr_slot(new_slot), .wr_data(mem_rsp_data),
    .rd_a_slot(a_slot), .rd_a_data(rd_a_data),
    .rd_b_slot(b_slot), .rd_b_data(rd_b_data),
    .cnt_slot(vic_slot), .cnt_val(vic_cnt),
    .free_slot(free_slot)
  );

  // Miss sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      miss_key_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE:  if (accept && !a_hit) begin
                    state_q    <= ST_DUPQ;
                    miss_key_q <= f_key;
                  end
        ST_DUPQ:  if (dup_take) state_q <= dup_res ? ST_IDLE : ST_MREQ;
        ST_MREQ:  if (mem_req_ready) state_q <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= (accept && a_hit) || dup_res || refill_done;
      resp_hit   <= accept && a_hit;
      if (accept && a_hit)  resp_data <= rd_a_data;
      else if (dup_res)     resp_data <= rd_b_data;
      else if (refill_done) resp_data <= mem_rsp_data;
    end
  end

  assign dup_req_valid = (state_q == ST_DUPQ);
  assign dup_req_key   = miss_key_q;
  assign mem_req_valid = (state_q == ST_MREQ);
  assign mem_req_key   = miss_key_q;
endmodule

// File: rtl/uc_icache_chk.sv
module uc_icache_chk #(
  parameter int KEY_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             fetch_valid,
  input logic             fetch_ready,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic             dup_req_valid,
  input logic [KEY_W-1:0] dup_req_key,
  input logic             dup_rsp_valid,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [KEY_W-1:0] mem_req_key
);
  assert_busy_in_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dup_req_valid || mem_req_valid) |-> !fetch_ready);

  assert_single_side_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dup_req_valid && mem_req_valid));

  assert_refill_key_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_key)));

  assert_query_key_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dup_req_valid && !dup_rsp_valid) |=> (dup_req_valid && $stable(dup_req_key)));

  assert_hit_follows_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> $past(fetch_valid && fetch_ready));

  assert_flush_blocks_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !fetch_ready);

  assert_flush_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !(resp_valid && resp_hit));
endmodule

bind uc_icache uc_icache_chk #(.KEY_W(KEY_W)) u_chk (.*);

// File: tb/test_uc_icache.sv
module test_uc_icache;
  localparam int ADDR_W = 16;
  localparam int BLK_W  = 256;
  localparam int KEY_W  = ADDR_W - 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              flush = 1'b0;
  logic              fetch_valid = 1'b0;
  logic              fetch_ready;
  logic [ADDR_W-1:0] fetch_addr = '0;
  logic              resp_valid, resp_hit;
  logic [BLK_W-1:0]  resp_data;
  logic              dup_req_valid;
  logic [KEY_W-1:0]  dup_req_key;
  logic              dup_rsp_valid = 1'b0;
  logic              dup_rsp_found = 1'b0;
  logic [KEY_W-1:0]  dup_rsp_key = '0;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b0;
  logic [KEY_W-1:0]  mem_req_key;
  logic              mem_rsp_valid = 1'b0;
  logic [BLK_W-1:0]  mem_rsp_data = '0;

  uc_icache #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .SETS(4), .WAYS(2)) i_uc_icache (.*);

  always #10 clk = ~clk;

  int vectors = 0, miscompares = 0;
  int mem_cnt = 0, dup_cnt = 0;
  logic [KEY_W-1:0] last_dup_key = '0, last_mem_key = '0;
  logic             tb_found = 1'b0;
  logic [KEY_W-1:0] tb_dkey = '0;
  bit               done = 1'b0;

  function automatic logic [BLK_W-1:0] blk(input logic [KEY_W-1:0] k);
    logic [BLK_W-1:0] r;
    for (int i = 0; i < 4; i++) r[64*i +: 64] = {16'hB10C, 8'(i), 29'd0, k};
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] adr(input logic [KEY_W-1:0] k);
    return {k, 5'd0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [BLK_W-1:0] act,
                     input logic [BLK_W-1:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Duplicate-table responder: answers in the cycle the query is seen.
  initial forever begin
    @(negedge clk);
    if (dup_rsp_valid) dup_rsp_valid = 1'b0;
    else if (dup_req_valid) begin
      dup_rsp_valid = 1'b1;
      dup_rsp_found = tb_found;
      dup_rsp_key   = tb_dkey;
      last_dup_key  = dup_req_key;
      dup_cnt++;
    end
  end

  // Lower-memory responder: ready after one cycle, data two cycles later.
  initial begin
    int wait_n;
    wait_n = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (wait_n > 0) begin
        wait_n--;
        if (wait_n == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = blk(last_mem_key);
        end
      end else if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        wait_n = 2;
        mem_cnt++;
      end else if (mem_req_valid) begin
        mem_req_ready = 1'b1;
        last_mem_key  = mem_req_key;
      end
    end
  end

  task automatic do_fetch(input logic [ADDR_W-1:0] a, input logic found,
                          input logic [KEY_W-1:0] dkey, output logic hit,
                          output logic [BLK_W-1:0] data, output int lat,
                          output logic rdy_after);
    tb_found = found;
    tb_dkey  = dkey;
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr  = a;
    while (!fetch_ready) @(negedge clk);
    @(negedge clk);
    fetch_valid = 1'b0;
    lat = 1;
    rdy_after = fetch_ready;
    while (!resp_valid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    hit  = resp_hit;
    data = resp_data;
  endtask

  // Hit expected: one cycle latency, hit flag, content, no side traffic.
  task automatic expect_hit(input logic [KEY_W-1:0] k, input logic [4:0] off,
                            input logic [KEY_W-1:0] ck, input string req);
    logic h; logic [BLK_W-1:0] d; int lat; logic r; int m0, d0;
    m0 = mem_cnt; d0 = dup_cnt;
    do_fetch({k, off}, 1'b0, '0, h, d, lat, r);
    chk(h == 1'b1 && lat == 1, req, BLK_W'({h, 8'(lat)}), BLK_W'({1'b1, 8'd1}));
    chk(d == blk(ck), req, d, blk(ck));
    chk(mem_cnt == m0 && dup_cnt == d0, req, BLK_W'(mem_cnt - m0 + dup_cnt - d0), '0);
  endtask

  task automatic expect_refill(input logic [KEY_W-1:0] k, input logic found,
                               input logic [KEY_W-1:0] dkey, input string req);
    logic h; logic [BLK_W-1:0] d; int lat; logic r; int m0, d0;
    m0 = mem_cnt; d0 = dup_cnt;
    do_fetch(adr(k), found, dkey, h, d, lat, r);
    chk(h == 1'b0 && r == 1'b0, {req, " R8"}, BLK_W'({h, r}), '0);
    chk(dup_cnt == d0 + 1 && last_dup_key == k, {req, " R3"}, BLK_W'(last_dup_key), BLK_W'(k));
    chk(mem_cnt == m0 + 1 && last_mem_key == k, {req, " R2"}, BLK_W'(last_mem_key), BLK_W'(k));
    chk(d == blk(k), {req, " R2"}, d, blk(k));
  endtask

  task automatic expect_dup(input logic [KEY_W-1:0] k, input logic [KEY_W-1:0] dkey,
                            input string req);
    logic h; logic [BLK_W-1:0] d; int lat; logic r; int m0, d0;
    m0 = mem_cnt; d0 = dup_cnt;
    do_fetch(adr(k), 1'b1, dkey, h, d, lat, r);
    chk(h == 1'b0 && dup_cnt == d0 + 1, {req, " R4"}, BLK_W'(h), '0);
    chk(mem_cnt == m0, {req, " R4 no refill"}, BLK_W'(mem_cnt - m0), '0);
    chk(d == blk(dkey), {req, " R4"}, d, blk(dkey));
  endtask

  // Block keys (set = key[1:0])
  localparam logic [KEY_W-1:0] KA = 11'h010, KB = 11'h014, KC = 11'h018, KD = 11'h01C;
  localparam logic [KEY_W-1:0] KX = 11'h021, KY = 11'h031, KZ = 11'h025, KN = 11'h044;

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fetch_ready && !resp_valid && !dup_req_valid && !mem_req_valid, "reset R8",
        BLK_W'({fetch_ready, resp_valid, dup_req_valid, mem_req_valid}), BLK_W'(4'b1000));
  endtask

  task automatic t_cold_and_hit;
    expect_refill(KA, 1'b0, '0, "cold miss");
    expect_hit(KA, 5'h1F, KA, "hit with offset R1 R11");
    expect_hit(KA, 5'h08, KA, "hit other offset R11");
  endtask

  task automatic t_duplicate;
    expect_dup(KX, KA, "dup into empty set");
    expect_hit(KX, 5'h00, KA, "alias tag hits R6");
    expect_refill(KY, 1'b1, KN, "dup not resident R2");
  endtask

  task automatic t_lru;
    expect_refill(KB, 1'b0, '0, "second way R7");
    expect_dup(KZ, KA, "dup with full set R5");
    expect_refill(KC, 1'b0, '0, "evict lru R7");
    expect_hit(KA, 5'h00, KA, "touched dup survives R5");
    expect_refill(KB, 1'b0, '0, "evicted way refills R7");
    expect_dup(KZ, KA, "full set no alias R6");
    expect_hit(KX, 5'h00, KA, "set intact R6");
    expect_hit(KY, 5'h00, KY, "set intact R6");
  endtask

  task automatic t_shared_slot;
    expect_refill(KC, 1'b0, '0, "fill set0 R7");
    expect_refill(KD, 1'b0, '0, "evict first owner R7");
    expect_hit(KX, 5'h00, KA, "shared slot kept R10");
    expect_refill(KA, 1'b0, '0, "owner gone R10");
  endtask

  task automatic t_flush;
    @(negedge clk);
    flush = 1'b1;
    #1;
    chk(!fetch_ready, "flush cycle R9", BLK_W'(fetch_ready), '0);
    @(negedge clk);
    flush = 1'b0;
    expect_refill(KB, 1'b0, '0, "after flush R9");
    expect_refill(KX, 1'b0, '0, "alias cleared R9");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_cold_and_hit();
    t_duplicate();
    t_lru();
    t_shared_slot();
    t_flush();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule